// File: doc/BRIEF.md
# Self-Corrected Min-Sum Row Processor

This block is the serial check-node engine of a layered LDPC decoder. A parity row is handled in two streamed passes. In the first pass the block takes in the row's posterior values, one edge per beat. For each edge it subtracts the extrinsic message it stored for that edge on the previous visit, which gives the prior. It then compares the prior's sign with the sign it recorded last time. A prior whose sign has flipped is treated as unreliable and erased to zero. The surviving magnitudes feed a running search for the two smallest values, their position and the parity of the signs.

In the second pass the block emits one new extrinsic value and one updated posterior per edge. If two or more inputs of a row were erased, every output of that row would have zero magnitude. In that case the row is skipped: nothing is emitted and the row's stored state is left untouched. The per-row state is kept in compressed form: two magnitudes, the index of the smallest, one extrinsic sign per edge, one prior sign per edge and a visited flag. A done strobe and the row's erased count are provided for the iteration controller.

Both data interfaces use valid/ready. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_row` must stay constant across all beats of a row. It is sampled on edge 0 of the row. `in_ready` is low from the cycle after the last input beat until the row completes. When `out_valid` is high and `out_ready` is low, `out_post` and `out_ext` hold their values. Both streams carry edges in order 0 to DEG-1.

Top module: `scms_row_proc`

## Requirements
- R1: The prior for an edge is the incoming posterior minus the extrinsic value stored for that edge, clamped to ±(2^(W-1)-1). Stored extrinsics are zero after reset.
- R2: The erasure rule applies on every visit to a row after its first visit that was not skipped. On such a visit, a prior whose sign bit differs from the stored prior sign of that edge is erased to magnitude 0 and positive sign. A negative value has sign bit 1, and zero counts as positive. On a first visit nothing is erased.
- R3: Each emitted extrinsic value works on the corrected inputs, with erased inputs counted as zero. Its magnitude is the smallest corrected magnitude among the other edges of the row. Its sign is negative exactly when an odd number of the other corrected inputs are negative.
- R4: After a row that is not skipped, the row's next visit subtracts exactly the extrinsic values emitted on this visit, and compares against the prior signs of this visit.
- R5: The updated posterior equals the prior plus the new extrinsic value, clamped to ±(2^(W-1)-1).
- R6: If a row has two or more erased inputs, it emits no output beat. It raises `done` together with `done_skip`, and its stored extrinsics, prior signs and visited flag stay unchanged.
- R7: `done` pulses high for one cycle at the end of every row. While it is high, `erased_cnt` gives that row's number of erased inputs.
- R8: Input and output beats follow valid/ready, in edge order 0 to DEG-1. Output data is held while it is stalled. `in_ready` is low while output beats are pending.
- R9: After reset, `in_ready` is high and `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Posterior beat valid |
| in_ready | output | 1 | Block accepts a posterior beat |
| in_row | input | $clog2(NROWS) | Row being processed, held for the whole row |
| in_post | input | W | Posterior value of the current edge, two's complement |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts a result beat |
| out_post | output | W | Updated posterior of the current edge |
| out_ext | output | W | New extrinsic value of the current edge |
| done | output | 1 | One-cycle pulse when a row finishes |
| done_skip | output | 1 | Qualifies `done`: the row was skipped |
| erased_cnt | output | $clog2(DEG+1) | Erased inputs of the finished row |

## Verification
The bench builds the block with W=6, DEG=4 and NROWS=4. With only four rows, randomly chosen rows are revisited again and again. This brings the sign-flip erasure, the skip path and the restored compressed state within reach many times in one run. Six-bit messages let inputs near ±31 drive both the prior and the posterior into their clamp limits. Four edges let the smallest magnitude fall on every index position, and random output stalls exercise the hold rule under back-pressure.

// File: rtl/scms_pkg.sv
package scms_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DECIDE  = 2'd1,
    ST_EMIT    = 2'd2
  } scms_phase_e;

  // symmetric clamp keeps the most negative code unused
  function automatic int clamp_sym(input int v, input int lim);
    if (v > lim) return lim;
    else if (v < -lim) return -lim;
    else return v;
  endfunction

endpackage

// File: rtl/scms_edge_prep.sv
module scms_edge_prep import scms_pkg::*; #(
  parameter int W   = 6,
  parameter int DEG = 4,
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int MW = W - 1
) (
  input  logic signed [W-1:0]  post,
  input  logic [IW-1:0]        edge_k,
  input  logic [MW-1:0]        st_m1,
  input  logic [MW-1:0]        st_m2,
  input  logic [IW-1:0]        st_idx,
  input  logic                 st_esgn,
  input  logic                 st_psgn,
  input  logic                 st_vis,
  output logic signed [W-1:0]  prior,
  output logic                 erased,
  output logic [MW-1:0]        k_mag,
  output logic                 k_sign
);
  localparam int MAXP = (1 << (W - 1)) - 1;

  logic [MW-1:0]      old_mag;
  logic signed [W:0]  old_ext;
  logic signed [W:0]  diff;

  always_comb begin
    old_mag = (edge_k == st_idx) ? st_m2 : st_m1;
    old_ext = st_esgn ? -$signed({2'b00, old_mag}) : $signed({2'b00, old_mag});
    diff    = $signed({post[W-1], post}) - old_ext;
    prior   = W'(clamp_sym(int'(diff), MAXP));
    erased  = st_vis && (prior[W-1] != st_psgn);
    k_sign  = erased ? 1'b0 : prior[W-1];
    if (erased)
      k_mag = '0;
    else if (prior[W-1])
      k_mag = MW'(-prior);
    else
      k_mag = prior[MW-1:0];
  end

endmodule

// File: rtl/scms_minfind.sv
module scms_minfind #(
  parameter int W   = 6,
  parameter int DEG = 4,
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int MW = W - 1,
  localparam int CW = $clog2(DEG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          first,
  input  logic [IW-1:0] k,
  input  logic [MW-1:0] mag,
  input  logic          sgn,
  input  logic          erased,
  output logic [MW-1:0] m1,
  output logic [MW-1:0] m2,
  output logic [IW-1:0] idx,
  output logic          tsgn,
  output logic [CW-1:0] ecnt
);
  logic [MW-1:0] m1_q, m2_q, b_m1, b_m2, n_m1, n_m2;
  logic [IW-1:0] idx_q, b_idx, n_idx;
  logic          s_q, b_s;
  logic [CW-1:0] c_q, b_c;

  always_comb begin
    b_m1  = first ? '1 : m1_q;
    b_m2  = first ? '1 : m2_q;
    b_idx = first ? '0 : idx_q;
    b_s   = first ? 1'b0 : s_q;
    b_c   = first ? '0 : c_q;
    n_m1  = b_m1;
    n_m2  = b_m2;
    n_idx = b_idx;
    if (mag < b_m1) begin
      n_m2  = b_m1;
      n_m1  = mag;
      n_idx = k;
    end else if (mag < b_m2) begin
      n_m2 = mag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_q  <= '1;
      m2_q  <= '1;
      idx_q <= '0;
      s_q   <= 1'b0;
      c_q   <= '0;
    end else if (upd) begin
      m1_q  <= n_m1;
      m2_q  <= n_m2;
      idx_q <= n_idx;
      s_q   <= b_s ^ sgn;
      c_q   <= b_c + CW'(erased);
    end
  end

  assign m1   = m1_q;
  assign m2   = m2_q;
  assign idx  = idx_q;
  assign tsgn = s_q;
  assign ecnt = c_q;

  assert_min_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m1_q <= m2_q) else $error("smallest above second smallest");

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(c_q) <= DEG) else $error("erased count beyond row degree");

endmodule

// File: rtl/scms_row_store.sv
module scms_row_store #(
  parameter int W     = 6,
  parameter int DEG   = 4,
  parameter int NROWS = 8,
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int RW = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int MW = W - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RW-1:0]  rd_row,
  output logic [MW-1:0]  rd_m1,
  output logic [MW-1:0]  rd_m2,
  output logic [IW-1:0]  rd_idx,
  output logic [DEG-1:0] rd_esgn,
  output logic [DEG-1:0] rd_psgn,
  output logic           rd_vis,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_row,
  input  logic [MW-1:0]  wr_m1,
  input  logic [MW-1:0]  wr_m2,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DEG-1:0] wr_esgn,
  input  logic [DEG-1:0] wr_psgn
);
  logic [MW-1:0]  m1_mem   [NROWS];
  logic [MW-1:0]  m2_mem   [NROWS];
  logic [IW-1:0]  idx_mem  [NROWS];
  logic [DEG-1:0] esgn_mem [NROWS];
  logic [DEG-1:0] psgn_mem [NROWS];
  logic [NROWS-1:0] vis_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NROWS; r++) begin
        m1_mem[r]   <= '0;
        m2_mem[r]   <= '0;
        idx_mem[r]  <= '0;
        esgn_mem[r] <= '0;
        psgn_mem[r] <= '0;
      end
      vis_q <= '0;
    end else if (wr_en) begin
      m1_mem[wr_row]   <= wr_m1;
      m2_mem[wr_row]   <= wr_m2;
      idx_mem[wr_row]  <= wr_idx;
      esgn_mem[wr_row] <= wr_esgn;
      psgn_mem[wr_row] <= wr_psgn;
      vis_q[wr_row]    <= 1'b1;
    end
  end

  assign rd_m1   = m1_mem[rd_row];
  assign rd_m2   = m2_mem[rd_row];
  assign rd_idx  = idx_mem[rd_row];
  assign rd_esgn = esgn_mem[rd_row];
  assign rd_psgn = psgn_mem[rd_row];
  assign rd_vis  = vis_q[rd_row];

  assert_store_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_m1 <= wr_m2) else $error("row written with unordered minima");

endmodule

// File: rtl/scms_row_proc.sv
module scms_row_proc import scms_pkg::*; #(
  parameter int W     = 6,
  parameter int DEG   = 4,
  parameter int NROWS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [$clog2(NROWS)-1:0]    in_row,
  input  logic signed [W-1:0]         in_post,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic signed [W-1:0]         out_post,
  output logic signed [W-1:0]         out_ext,
  output logic                        done,
  output logic                        done_skip,
  output logic [$clog2(DEG+1)-1:0]    erased_cnt
);
  localparam int IW   = (DEG > 1) ? $clog2(DEG) : 1;
  localparam int RW   = $clog2(NROWS);
  localparam int MW   = W - 1;
  localparam int CW   = $clog2(DEG + 1);
  localparam int MAXP = (1 << (W - 1)) - 1;

  scms_phase_e          phase_q;
  logic [IW-1:0]        k_q;
  logic [RW-1:0]        row_q;
  logic signed [W-1:0]  pri_q [DEG];
  logic [DEG-1:0]       ksgn_q, psn_q;
  logic                 done_q, skip_q;
  logic [CW-1:0]        cnt_q;

  logic in_fire, out_fire, last_k, skip_now;
  assign in_ready  = (phase_q == ST_COLLECT);
  assign out_valid = (phase_q == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign last_k    = (k_q == IW'(DEG - 1));

  // row state read
  logic [RW-1:0]  rd_row;
  logic [MW-1:0]  st_m1, st_m2;
  logic [IW-1:0]  st_idx;
  logic [DEG-1:0] st_esgn, st_psgn;
  logic           st_vis;
  assign rd_row = (k_q == '0) ? in_row : row_q;

  // pass one datapath
  logic signed [W-1:0] prior;
  logic                erased, k_sign;
  logic [MW-1:0]       k_mag;
  logic [MW-1:0]       mf_m1, mf_m2;
  logic [IW-1:0]       mf_idx;
  logic                mf_s;
  logic [CW-1:0]       mf_cnt;

  scms_edge_prep #(.W(W), .DEG(DEG)) u_prep (
    .post(in_post), .edge_k(k_q), .st_m1(st_m1), .st_m2(st_m2), .st_idx(st_idx),
    .st_esgn(st_esgn[k_q]), .st_psgn(st_psgn[k_q]), .st_vis(st_vis),
    .prior(prior), .erased(erased), .k_mag(k_mag), .k_sign(k_sign)
  );

  scms_minfind #(.W(W), .DEG(DEG)) u_min (
    .clk(clk), .rst_n(rst_n), .upd(in_fire), .first(k_q == '0), .k(k_q),
    .mag(k_mag), .sgn(k_sign), .erased(erased),
    .m1(mf_m1), .m2(mf_m2), .idx(mf_idx), .tsgn(mf_s), .ecnt(mf_cnt)
  );

  assign skip_now = (mf_cnt >= CW'(2));

  logic wr_en;
  assign wr_en = (phase_q == ST_DECIDE) && !skip_now;

  scms_row_store #(.W(W), .DEG(DEG), .NROWS(NROWS)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_row(rd_row),
    .rd_m1(st_m1), .rd_m2(st_m2), .rd_idx(st_idx),
    .rd_esgn(st_esgn), .rd_psgn(st_psgn), .rd_vis(st_vis),
    .wr_en(wr_en), .wr_row(row_q), .wr_m1(mf_m1), .wr_m2(mf_m2), .wr_idx(mf_idx),
    .wr_esgn({DEG{mf_s}} ^ ksgn_q), .wr_psgn(psn_q)
  );

  // pass two datapath
  logic [MW-1:0]     e_mag;
  logic              e_sgn;
  logic signed [W:0] sum;
  always_comb begin
    e_mag    = (k_q == mf_idx) ? mf_m2 : mf_m1;
    e_sgn    = mf_s ^ ksgn_q[k_q];
    out_ext  = e_sgn ? -$signed({1'b0, e_mag}) : $signed({1'b0, e_mag});
    sum      = $signed({pri_q[k_q][W-1], pri_q[k_q]}) + $signed({out_ext[W-1], out_ext});
    out_post = W'(clamp_sym(int'(sum), MAXP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_COLLECT;
      k_q     <= '0;
      row_q   <= '0;
      ksgn_q  <= '0;
      psn_q   <= '0;
      done_q  <= 1'b0;
      skip_q  <= 1'b0;
      cnt_q   <= '0;
      for (int e = 0; e < DEG; e++) pri_q[e] <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        ST_COLLECT: if (in_fire) begin
          pri_q[k_q]  <= prior;
          ksgn_q[k_q] <= k_sign;
          psn_q[k_q]  <= prior[W-1];
          if (k_q == '0) row_q <= in_row;
          if (last_k) begin
            k_q     <= '0;
            phase_q <= ST_DECIDE;
          end else begin
            k_q <= k_q + IW'(1);
          end
        end
        ST_DECIDE: begin
          cnt_q  <= mf_cnt;
          skip_q <= skip_now;
          if (skip_now) begin
            done_q  <= 1'b1;
            phase_q <= ST_COLLECT;
          end else begin
            phase_q <= ST_EMIT;
          end
        end
        ST_EMIT: if (out_fire) begin
          if (last_k) begin
            k_q     <= '0;
            done_q  <= 1'b1;
            phase_q <= ST_COLLECT;
          end else begin
            k_q <= k_q + IW'(1);
          end
        end
        default: phase_q <= ST_COLLECT;
      endcase
    end
  end

  assign done       = done_q;
  assign done_skip  = skip_q;
  assign erased_cnt = cnt_q;

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_post) && $stable(out_ext))
    else $error("result beat changed while stalled");

  assert_skip_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_skip |-> erased_cnt >= CW'(2)) else $error("skip with few erasures");

  assert_emit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_skip |-> erased_cnt < CW'(2)) else $error("decoded row with many erasures");

endmodule

// File: tb/tb_scms_row_proc.sv
`timescale 1ns/1ps
module tb_scms_row_proc;
  localparam int W   = 6;
  localparam int DEG = 4;
  localparam int NR  = 4;
  localparam int RW  = $clog2(NR);
  localparam int CW  = $clog2(DEG + 1);
  localparam int LIM = 31;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                rst_n, in_valid, out_ready, in_ready, out_valid, done, done_skip;
  logic [RW-1:0]       in_row;
  logic signed [W-1:0] in_post, out_post, out_ext;
  logic [CW-1:0]       erased_cnt;

  scms_row_proc #(.W(W), .DEG(DEG), .NROWS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_post(in_post), .out_valid(out_valid), .out_ready(out_ready),
    .out_post(out_post), .out_ext(out_ext), .done(done), .done_skip(done_skip),
    .erased_cnt(erased_cnt)
  );

  int total = 0, bad = 0;
  int m_ext [NR][DEG];
  bit m_ps  [NR][DEG];
  bit m_vis [NR];
  int pol   [NR][DEG];
  int stim [DEG];
  int exp_ext [DEG];
  int exp_post [DEG];
  bit exp_skip;
  int exp_cnt;

  function automatic int sat(input int v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic model_row(input int row);
    int p [DEG];
    int kap [DEG];
    int cnt;
    cnt = 0;
    for (int k = 0; k < DEG; k++) begin
      p[k] = sat(stim[k] - m_ext[row][k]);
      if (m_vis[row] && ((p[k] < 0) != m_ps[row][k])) begin
        kap[k] = 0;
        cnt++;
      end else kap[k] = p[k];
    end
    for (int j = 0; j < DEG; j++) begin
      int mn;
      bit s;
      mn = 1000;
      s = 1'b0;
      for (int n = 0; n < DEG; n++) if (n != j) begin
        if ((kap[n] < 0 ? -kap[n] : kap[n]) < mn) mn = (kap[n] < 0 ? -kap[n] : kap[n]);
        if (kap[n] < 0) s = ~s;
      end
      exp_ext[j]  = s ? -mn : mn;
      exp_post[j] = sat(p[j] + exp_ext[j]);
    end
    exp_cnt  = cnt;
    exp_skip = (cnt >= 2);
    if (!exp_skip) begin
      for (int k = 0; k < DEG; k++) begin
        m_ext[row][k] = exp_ext[k];
        m_ps[row][k]  = (p[k] < 0);
      end
      m_vis[row] = 1'b1;
    end
  endtask

  task automatic run_row(input int row, input bit stall);
    int beats;
    bit seen;
    int guard;
    model_row(row);
    for (int k = 0; k < DEG; k++) begin
      int gap;
      gap = stall ? $urandom_range(0, 2) : 0;
      repeat (gap) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_row   = RW'(row);
      in_post  = W'(stim[k]);
      check(in_ready == 1'b1, "R8 in_ready during input pass", int'(in_ready), 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    beats = 0;
    seen  = 1'b0;
    guard = 0;
    while (!seen && guard < 200) begin
      guard++;
      if (done) begin
        seen = 1'b1;
        check(done_skip == exp_skip, "R6 skip flag", int'(done_skip), int'(exp_skip));
        check(int'(erased_cnt) == exp_cnt, "R2 R7 erased count", int'(erased_cnt), exp_cnt);
        check(beats == (exp_skip ? 0 : DEG), "R6 R8 beat count", beats, exp_skip ? 0 : DEG);
      end else if (out_valid) begin
        check(in_ready == 1'b0, "R8 in_ready low while emitting", int'(in_ready), 0);
        if (beats < DEG) begin
          check(int'(out_ext) == exp_ext[beats], "R1 R3 R4 extrinsic",
                int'(out_ext), exp_ext[beats]);
          check(int'(out_post) == exp_post[beats], "R5 posterior",
                int'(out_post), exp_post[beats]);
        end else begin
          check(1'b0, "R8 extra beat", beats, DEG);
        end
        out_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
        if (out_ready) beats++;
      end else begin
        out_ready = 1'b0;
      end
      if (!seen) @(negedge clk);
    end
    if (!seen) check(1'b0, "R7 done missing", 0, 1);
    out_ready = 1'b0;
  endtask

  task automatic set4(input int a, input int b, input int c, input int d);
    stim[0] = a; stim[1] = b; stim[2] = c; stim[3] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R8 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin
      m_vis[r] = 1'b0;
      for (int k = 0; k < DEG; k++) begin
        m_ext[r][k] = 0;
        m_ps[r][k]  = 1'b0;
        pol[r][k]   = 1;
      end
    end
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_row = '0; in_post = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(done == 1'b0, "R9 done after reset", int'(done), 0);

    // first visit: zero stored extrinsics, no erasure (R1, R2)
    set4(10, -3, 7, 20);   run_row(0, 1'b0);
    // revisit subtracts the stored extrinsics (R4)
    set4(10, -3, 7, 20);   run_row(0, 1'b1);
    // all signs flip: skipped row, state kept (R6)
    set4(20, 20, 20, 20);  run_row(1, 1'b0);
    set4(-20, -20, -20, -20); run_row(1, 1'b0);
    set4(20, 20, 20, 20);  run_row(1, 1'b0);
    // single erasure: row still decoded with zero on others (R2, R3)
    set4(15, -9, 12, 5);   run_row(3, 1'b0);
    set4(15, 9, 12, 5);    run_row(3, 1'b1);
    // clamp limits (R1, R5)
    set4(31, 31, 31, 31);  run_row(2, 1'b0);
    set4(-31, 31, 31, 31); run_row(2, 1'b1);

    for (int i = 0; i < 300; i++) begin
      int row;
      row = $urandom_range(0, NR - 1);
      for (int k = 0; k < DEG; k++) begin
        if ($urandom_range(0, 4) == 0) pol[row][k] = -pol[row][k];
        stim[k] = pol[row][k] * int'($urandom_range(0, 31));
      end
      run_row(row, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule